// File: doc/BRIEF.md
# FIFO-Level Paced Nibble Frame Transmitter

This block sits on the receive side of a link adapter. It takes bytes one at a time from an upstream source, each byte carrying an end-of-frame marker, and stores them in a byte FIFO. It then sends whole frames out as a stream of 4-bit nibbles with a data-valid strobe, in the style of a media-independent interface. Between two frames it always leaves a minimum idle gap, counted in output clock cycles.

The length of that gap is not fixed. A hysteresis controller watches how many bytes are held in the FIFO. When the FIFO fills up to a high watermark, it selects a short gap so that the backlog drains faster. When the FIFO has drained down to a low watermark, it goes back to the normal gap. Both watermarks, and a threshold that lets a frame start before all of it has arrived, are inputs that the surrounding logic drives. The normal gap, the short gap and the FIFO depth are parameters.

Top module: `fill_paced_nibble_tx`

## Requirements
- R1: At every clock edge where `fill_level` >= `hi_mark`, `gap_low` is 1 in the following cycle. This rule takes priority over R2.
- R2: At every clock edge where `fill_level` <= `lo_mark` and `fill_level` < `hi_mark`, `gap_low` is 0 in the following cycle.
- R3: After reset, `mii_dv` is 0, `gap_low` is 0, `fill_level` is 0 and `overflow` is 0.
- R4: While `lo_mark` < `fill_level` < `hi_mark`, `gap_low` keeps its previous value.
- R5: When a frame's last nibble is sent while `gap_low` is 0, at least NORM_GAP cycles (24 by default) with `mii_dv` low follow. If the next frame is ready, it starts after exactly NORM_GAP cycles.
- R6: When a frame's last nibble is sent while `gap_low` is 1, at least LOW_GAP cycles (8 by default) with `mii_dv` low follow. If the next frame is ready, it starts after exactly LOW_GAP cycles.
- R7: Each byte goes out over two consecutive cycles, with bits [3:0] on `mii_txd` first and bits [7:4] second. `mii_dv` is high on both cycles. It stays high across all bytes of a frame as long as the next byte is already in the FIFO.
- R8: A frame starts only when the FIFO is not empty and either holds at least one complete frame (a byte written with `wr_last`=1) or `fill_level` >= `tx_thresh`. Otherwise `mii_dv` stays 0.
- R9: `fill_level` counts the bytes written minus the bytes taken for output. A byte is taken on the clock edge where its low nibble is placed on `mii_txd`. A write is counted one edge after it is presented.
- R10: A write made while `fill_level` equals DEPTH is discarded and never appears on the output. It sets `overflow`, which stays 1 until reset.
- R11: If the FIFO runs empty in the middle of a frame, `mii_dv` drops. The frame continues with the next byte written, and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write side and the nibble output |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | Marks the written byte as the last byte of its frame |
| hi_mark | input | MARK_W (12) | Occupancy in bytes at or above which the short gap is selected |
| lo_mark | input | MARK_W (12) | Occupancy in bytes at or below which the normal gap is selected |
| tx_thresh | input | THRESH_W (11) | Occupancy at which a frame may start before it is complete |
| mii_txd | output | 4 | Output nibble |
| mii_dv | output | 1 | Output data-valid |
| gap_low | output | 1 | Gap select: 1 = short gap, 0 = normal gap |
| fill_level | output | CW (12) | Number of bytes held in the FIFO |
| overflow | output | 1 | Sticky flag: a write was discarded because the FIFO was full |

## Verification
A write presented before a rising edge is counted in `fill_level` right after that edge. `gap_low` follows one edge after that. The bench changes inputs on falling edges and waits at least three cycles before it reads `fill_level` or `gap_low`, so every stage of this chain has settled. A frame that is ready starts one edge after the start condition holds, and the gap is counted in whole cycles from the edge that ends the last nibble. A monitor samples `mii_dv` and `mii_txd` on every falling edge. It measures each idle gap as the number of low samples, counts the nibbles in each burst, and rebuilds the bytes. Each frame is given enough drain time before these measurements are compared.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  // Power-up value recommended for the high watermark (bytes).
  localparam int unsigned HI_MARK_RESET = 1536;

  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,   // no frame on the bus (gap or waiting)
    DR_NLO   = 2'd1,   // low nibble of the held byte is on the bus
    DR_NHI   = 2'd2,   // high nibble of the held byte is on the bus
    DR_STALL = 2'd3    // mid-frame, FIFO ran dry
  } drain_state_e;

  // Next value of the gap-select flag; the high mark wins a tie.
  function automatic logic hyst_next(logic cur, int unsigned occ,
                                     int unsigned hi, int unsigned lo);
    if (occ >= hi) return 1'b1;
    if (occ <= lo) return 1'b0;
    return cur;
  endfunction

  // Gap length in output cycles for a given selection.
  function automatic int unsigned gap_cycles(logic low_sel, int unsigned norm,
                                             int unsigned lowg);
    return low_sel ? lowg : norm;
  endfunction

  // A new frame may begin when data exists and either a whole frame is
  // present or the fill has reached the early-start threshold.
  function automatic logic drain_ready(logic empty, int unsigned frames,
                                       int unsigned occ, int unsigned thresh);
    return !empty && ((frames != 0) || (occ >= thresh));
  endfunction

  // Occupancy update for one clock.
  function automatic int unsigned occ_step(int unsigned occ, logic push, logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/pacer_byte_store.sv
module pacer_byte_store
  import pacer_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [7:0]    push_data,
  input  logic          push_last,
  input  logic          pop,
  output logic [7:0]    head_data,
  output logic          head_last,
  output logic [CW-1:0] occupancy,
  output logic [CW-1:0] frames_held,
  output logic          empty,
  output logic          overflow
);

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q, frames_q;
  logic          ovf_q;
  logic          full, push_ok, drop_evt;
  logic          frame_in, frame_out;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
  assign push_ok   = push_req && !full;
  assign drop_evt  = push_req && full;
  assign head_data = mem[rptr_q][7:0];
  assign head_last = mem[rptr_q][8];
  assign frame_in  = push_ok && push_last;
  assign frame_out = pop && head_last;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= {push_last, push_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      count_q  <= '0;
      frames_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push_ok) wptr_q <= ptr_inc(wptr_q);
      if (pop)     rptr_q <= ptr_inc(rptr_q);
      count_q  <= CW'(occ_step(32'(count_q), push_ok, pop));
      frames_q <= CW'(occ_step(32'(frames_q), frame_in, frame_out));
      if (drop_evt) ovf_q <= 1'b1;
    end
  end

  assign occupancy   = count_q;
  assign frames_held = frames_q;
  assign overflow    = ovf_q;

endmodule

// File: rtl/pacer_gap_hyst.sv
module pacer_gap_hyst
  import pacer_pkg::*;
#(
  parameter int CW     = 12,
  parameter int MARK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     occupancy,
  input  logic [MARK_W-1:0] hi_mark,
  input  logic [MARK_W-1:0] lo_mark,
  output logic              low_gap_sel
);

  logic sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= hyst_next(sel_q, 32'(occupancy), 32'(hi_mark), 32'(lo_mark));
  end

  assign low_gap_sel = sel_q;

endmodule

// File: rtl/pacer_nibble_drain.sv
module pacer_nibble_drain
  import pacer_pkg::*;
#(
  parameter int CW       = 12,
  parameter int THRESH_W = 11,
  parameter int NORM_GAP = 24,
  parameter int LOW_GAP  = 8,
  localparam int GMAX    = (NORM_GAP > LOW_GAP) ? NORM_GAP : LOW_GAP,
  localparam int GW      = $clog2(GMAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       occupancy,
  input  logic [CW-1:0]       frames_held,
  input  logic                empty,
  input  logic [7:0]          head_data,
  input  logic                head_last,
  input  logic [THRESH_W-1:0] tx_thresh,
  input  logic                low_gap_sel,
  output logic                pop,
  output logic [3:0]          txd,
  output logic                dv,
  output logic                start_evt,
  output logic                last_nib_evt
);

  drain_state_e  state_q;
  logic [3:0]    hi_nib_q;
  logic          last_q;
  logic [GW-1:0] gap_q;
  logic [3:0]    txd_q;
  logic          dv_q;
  logic          ready;
  logic          resume_evt;
  logic [GW-1:0] gap_load;

  assign ready = drain_ready(empty, 32'(frames_held), 32'(occupancy), 32'(tx_thresh));
  // gap of G idle cycles: counter loaded with G-1, start on the edge it reads 0
  assign gap_load = GW'(gap_cycles(low_gap_sel, NORM_GAP, LOW_GAP) - 1);

  assign start_evt    = (state_q == DR_IDLE) && (gap_q == '0) && ready;
  assign last_nib_evt = (state_q == DR_NHI) && last_q;
  assign resume_evt   = ((state_q == DR_NHI) && !last_q && !empty) ||
                        ((state_q == DR_STALL) && !empty);
  assign pop          = start_evt || resume_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= DR_IDLE;
      hi_nib_q <= '0;
      last_q   <= 1'b0;
      gap_q    <= '0;
      txd_q    <= '0;
      dv_q     <= 1'b0;
    end else begin
      if (pop) begin
        hi_nib_q <= head_data[7:4];
        last_q   <= head_last;
        txd_q    <= head_data[3:0];
        dv_q     <= 1'b1;
        state_q  <= DR_NLO;
      end else begin
        unique case (state_q)
          DR_IDLE: begin
            if (gap_q != '0) gap_q <= gap_q - GW'(1);
          end
          DR_NLO: begin
            txd_q   <= hi_nib_q;
            state_q <= DR_NHI;
          end
          DR_NHI: begin
            txd_q <= '0;
            dv_q  <= 1'b0;
            if (last_q) begin
              gap_q   <= gap_load;
              state_q <= DR_IDLE;
            end else begin
              state_q <= DR_STALL;
            end
          end
          DR_STALL: begin
            state_q <= DR_STALL;
          end
          default: state_q <= DR_IDLE;
        endcase
      end
    end
  end

  assign txd = txd_q;
  assign dv  = dv_q;

endmodule

// File: rtl/fill_paced_nibble_tx.sv
module fill_paced_nibble_tx
  import pacer_pkg::*;
#(
  parameter int DEPTH    = 2048,
  parameter int MARK_W   = 12,
  parameter int THRESH_W = 11,
  parameter int NORM_GAP = 24,
  parameter int LOW_GAP  = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic                wr_last,
  input  logic [MARK_W-1:0]   hi_mark,
  input  logic [MARK_W-1:0]   lo_mark,
  input  logic [THRESH_W-1:0] tx_thresh,
  output logic [3:0]          mii_txd,
  output logic                mii_dv,
  output logic                gap_low,
  output logic [CW-1:0]       fill_level,
  output logic                overflow
);

  // named internal events, also observed by the bound checker
  logic          pop;
  logic          start_evt;
  logic          last_nib_evt;
  logic [7:0]    head_data;
  logic          head_last;
  logic [CW-1:0] occupancy;
  logic [CW-1:0] frames_held;
  logic          empty;
  logic          low_gap_sel;

  pacer_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_req    (wr_en),
    .push_data   (wr_data),
    .push_last   (wr_last),
    .pop         (pop),
    .head_data   (head_data),
    .head_last   (head_last),
    .occupancy   (occupancy),
    .frames_held (frames_held),
    .empty       (empty),
    .overflow    (overflow)
  );

  pacer_gap_hyst #(.CW(CW), .MARK_W(MARK_W)) u_hyst (
    .clk         (clk),
    .rst_n       (rst_n),
    .occupancy   (occupancy),
    .hi_mark     (hi_mark),
    .lo_mark     (lo_mark),
    .low_gap_sel (low_gap_sel)
  );

  pacer_nibble_drain #(
    .CW(CW), .THRESH_W(THRESH_W), .NORM_GAP(NORM_GAP), .LOW_GAP(LOW_GAP)
  ) u_drain (
    .clk          (clk),
    .rst_n        (rst_n),
    .occupancy    (occupancy),
    .frames_held  (frames_held),
    .empty        (empty),
    .head_data    (head_data),
    .head_last    (head_last),
    .tx_thresh    (tx_thresh),
    .low_gap_sel  (low_gap_sel),
    .pop          (pop),
    .txd          (mii_txd),
    .dv           (mii_dv),
    .start_evt    (start_evt),
    .last_nib_evt (last_nib_evt)
  );

  assign gap_low    = low_gap_sel;
  assign fill_level = occupancy;

endmodule

// File: rtl/pacer_checker.sv
module pacer_checker #(
  parameter int DEPTH    = 2048,
  parameter int MARK_W   = 12,
  parameter int NORM_GAP = 24,
  parameter int LOW_GAP  = 8,
  parameter int CW       = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [MARK_W-1:0] hi_mark,
  input logic [MARK_W-1:0] lo_mark,
  input logic              mii_dv,
  input logic              gap_low,
  input logic [CW-1:0]     fill_level,
  input logic              overflow,
  input logic              start_evt,
  input logic              last_nib_evt
);

  // idle cycles since the last frame ended, and the gap owed at that point
  logic [15:0] idle_q;
  logic [15:0] owed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q <= 16'hFFFF;
      owed_q <= '0;
    end else if (last_nib_evt) begin
      idle_q <= '0;
      owed_q <= gap_low ? 16'(LOW_GAP) : 16'(NORM_GAP);
    end else if (!mii_dv && idle_q != 16'hFFFF) begin
      idle_q <= idle_q + 16'd1;
    end
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fill_level) >= 32'(hi_mark)) |=> gap_low);  // R1

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fill_level) <= 32'(lo_mark) && 32'(fill_level) < 32'(hi_mark)) |=> !gap_low);  // R2

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fill_level) > 32'(lo_mark) && 32'(fill_level) < 32'(hi_mark)) |=> $stable(gap_low));  // R4

  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (32'(idle_q) + 1 >= 32'(owed_q)));  // R5

  AST_LAST_NIBBLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_nib_evt |-> mii_dv);  // R7

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill_level) <= DEPTH);  // R9

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);  // R10

  AST_OVERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!overflow && !(wr_en && 32'(fill_level) == DEPTH)) |=> !overflow);  // R10

endmodule

bind fill_paced_nibble_tx pacer_checker #(
  .DEPTH(DEPTH), .MARK_W(MARK_W), .NORM_GAP(NORM_GAP), .LOW_GAP(LOW_GAP), .CW(CW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .hi_mark      (hi_mark),
  .lo_mark      (lo_mark),
  .mii_dv       (mii_dv),
  .gap_low      (gap_low),
  .fill_level   (fill_level),
  .overflow     (overflow),
  .start_evt    (start_evt),
  .last_nib_evt (last_nib_evt)
);

// File: tb/tb_fill_paced_nibble_tx.sv
`timescale 1ns/1ps
module tb_fill_paced_nibble_tx;
  import pacer_pkg::*;

  localparam int TB_DEPTH = 64;
  localparam int TB_CW    = $clog2(TB_DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [7:0]        wr_data;
  logic              wr_last;
  logic [11:0]       hi_mark, lo_mark;
  logic [10:0]       tx_thresh;
  logic [3:0]        mii_txd;
  logic              mii_dv, gap_low, overflow;
  logic [TB_CW-1:0]  fill_level;

  always #10 clk = ~clk;  // 50 MHz

  fill_paced_nibble_tx #(.DEPTH(TB_DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
    .hi_mark(hi_mark), .lo_mark(lo_mark), .tx_thresh(tx_thresh),
    .mii_txd(mii_txd), .mii_dv(mii_dv), .gap_low(gap_low),
    .fill_level(fill_level), .overflow(overflow)
  );

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- output monitor ----------------
  logic [7:0] rx_buf [256];
  int   rx_n, rises, idle, last_gap, nibs, last_nibs;
  bit   phase, prev_dv;
  logic [3:0] lo_nib;

  always @(negedge clk) begin
    if (!rst_n) begin
      rx_n = 0; rises = 0; idle = 0; last_gap = -1; nibs = 0; last_nibs = 0;
      phase = 1'b0; prev_dv = 1'b0; lo_nib = '0;
    end else begin
      if (mii_dv) begin
        if (!prev_dv) begin
          last_gap = idle;
          rises++;
        end
        nibs++;
        if (!phase) lo_nib = mii_txd;
        else if (rx_n < 256) begin
          rx_buf[rx_n] = {mii_txd, lo_nib};
          rx_n++;
        end
        phase = ~phase;
      end else begin
        if (prev_dv) begin
          last_nibs = nibs;
          nibs = 0;
          idle = 1;
        end else begin
          idle++;
        end
      end
      prev_dv = mii_dv;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic put(input logic [7:0] d, input bit last);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_last = last;
  endtask

  task automatic put_idle();
    @(negedge clk);
    wr_en = 1'b0; wr_last = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- hysteresis vector table ----------------
  typedef struct packed {
    int nwr;
    int hi;
    int lo;
    int exp_flag;
    int exp_fill;
  } step_t;

  localparam step_t STEPS [6] = '{
    '{9,  10, 4,  0, 9 },   // R4 between marks from reset: stays 0
    '{1,  10, 4,  1, 10},   // R1 fill reaches high mark
    '{0,  20, 4,  1, 10},   // R4 raised high mark: holds 1
    '{0,  20, 10, 0, 10},   // R2 fill equals low mark
    '{0,  20, 4,  0, 10},   // R4 between marks: holds 0
    '{10, 20, 4,  1, 20}    // R1 equality with high mark
  };

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_last = 1'b0;
    hi_mark = 12'(HI_MARK_RESET); lo_mark = '0; tx_thresh = 11'd2047;

    // ---- R3 reset state ----
    do_reset();
    check_eq("R3", "mii_dv after reset", int'(mii_dv), 0);
    check_eq("R3", "gap_low after reset", int'(gap_low), 0);
    check_eq("R3", "fill_level after reset", int'(fill_level), 0);
    check_eq("R3", "overflow after reset", int'(overflow), 0);

    // ---- table walk: R1 R2 R4 R9 ----
    begin
      int wcount = 0;
      foreach (STEPS[i]) begin
        @(negedge clk);
        hi_mark = 12'(STEPS[i].hi);
        lo_mark = 12'(STEPS[i].lo);
        for (int k = 0; k < STEPS[i].nwr; k++) begin
          put(8'(wcount), 1'b0);
          wcount++;
        end
        put_idle();
        settle(3);
        check_eq("R1/R2/R4", $sformatf("gap_low step %0d", i), int'(gap_low), STEPS[i].exp_flag);
        check_eq("R9", $sformatf("fill_level step %0d", i), int'(fill_level), STEPS[i].exp_fill);
        check_eq("R8", $sformatf("no start on partial frame step %0d", i), rises, 0);
      end
      // close the frame: all 21 bytes drain, fill falls to the low mark
      put(8'hF0, 1'b1);
      put_idle();
      settle(80);
      check_eq("R9", "fill after drain", int'(fill_level), 0);
      check_eq("R2", "gap_low after drain", int'(gap_low), 0);
      check_eq("R7", "bytes of drained frame", rx_n, 21);
      check_eq("R7", "nibbles in one burst", last_nibs, 42);
    end

    // ---- R5 normal gap and R7 nibble order ----
    do_reset();
    hi_mark = 12'(HI_MARK_RESET); lo_mark = '0; tx_thresh = 11'd2047;
    begin
      logic [7:0] exp_b [8] = '{8'h5A, 8'hC3, 8'h81, 8'h7E, 8'h19, 8'hD2, 8'h4B, 8'hF6};
      for (int k = 0; k < 8; k++) put(exp_b[k], (k == 4) || (k == 7));
      put_idle();
      settle(100);
      check_eq("R5", "normal gap length", last_gap, 24);
      check_eq("R7", "second frame nibbles", last_nibs, 6);
      check_eq("R7", "bytes received", rx_n, 8);
      for (int k = 0; k < 8; k++)
        check_eq("R7", $sformatf("byte %0d low nibble first", k), int'(rx_buf[k]), int'(exp_b[k]));
    end

    // ---- R6 low gap ----
    do_reset();
    hi_mark = 12'd4; lo_mark = 12'd1; tx_thresh = 11'd2047;
    for (int k = 0; k < 12; k++) put(8'(8'hA0 + k), (k == 5) || (k == 11));
    put_idle();
    settle(100);
    check_eq("R6", "low gap length", last_gap, 8);
    check_eq("R6", "frames sent", rises, 2);
    check_eq("R6", "first byte of second frame", int'(rx_buf[6]), 8'hA6);

    // ---- R8 early start by threshold ----
    do_reset();
    hi_mark = 12'(HI_MARK_RESET); lo_mark = '0; tx_thresh = 11'd3;
    put(8'h10, 1'b0);
    put(8'h11, 1'b0);
    put_idle();
    settle(20);
    check_eq("R8", "below threshold stays idle", int'(mii_dv), 0);
    check_eq("R8", "below threshold no frame", rises, 0);
    for (int k = 2; k < 6; k++) put(8'(8'h10 + k), k == 5);
    put_idle();
    settle(60);
    check_eq("R8", "threshold frame started once", rises, 1);
    check_eq("R8", "threshold frame bytes", rx_n, 6);
    check_eq("R7", "threshold frame continuous", last_nibs, 12);

    // ---- R10 overflow and R11 underrun ----
    do_reset();
    hi_mark = 12'(HI_MARK_RESET); lo_mark = '0; tx_thresh = 11'd2047;
    for (int k = 0; k < TB_DEPTH; k++) put(8'(k), 1'b0);
    put_idle();
    settle(2);
    check_eq("R9", "fill at depth", int'(fill_level), TB_DEPTH);
    check_eq("R10", "overflow before drop", int'(overflow), 0);
    put(8'hEE, 1'b1);
    put_idle();
    settle(2);
    check_eq("R10", "fill after dropped write", int'(fill_level), TB_DEPTH);
    check_eq("R10", "overflow set", int'(overflow), 1);
    check_eq("R10", "dropped last byte started nothing", rises, 0);
    @(negedge clk);
    tx_thresh = 11'd1;
    settle(200);
    check_eq("R11", "stalled mid-frame dv low", int'(mii_dv), 0);
    check_eq("R11", "bytes before stall", rx_n, TB_DEPTH);
    check_eq("R10", "overflow sticky", int'(overflow), 1);
    put(8'h77, 1'b1);
    put_idle();
    settle(20);
    check_eq("R11", "bytes after resume", rx_n, TB_DEPTH + 1);
    check_eq("R11", "resumed byte", int'(rx_buf[TB_DEPTH]), 8'h77);
    begin
      int bad = 0;
      for (int k = 0; k < TB_DEPTH; k++) if (rx_buf[k] != 8'(k)) bad++;
      check_eq("R10", "stored bytes intact, dropped byte absent", bad, 0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule